// File: doc/BRIEF.md
# Gaussian Noise Sample Generator

This block produces a stream of quantized, approximately Gaussian noise samples for a channel emulator. It uses the Box-Muller transform. Two 64-bit linear feedback shift registers supply independent uniform words. The top byte of the first word selects a radius value, sqrt(-2 ln u). The top byte of the second word selects a cosine value, cos(2πu). Both values come from tables that are computed when the design elaborates. The block multiplies the two values, scales the product by a programmable standard deviation, rounds the result and clamps it to a 6-bit two's-complement word.

Many copies run in parallel in a full emulator, so each copy takes its own pair of seeds through a load strobe. Each clock with the enable high starts one sample. The matching sample appears with a valid flag three clock edges later. The consumer sets the standard deviation from its signal-to-noise target. Its unit is one sixteenth of an output step.

Top module: `gauss_noise_gen`

## Requirements
- R1: While reset is asserted, and at the first sample point after it is released, `sample_valid` is 0 and `sample` is 0.
- R2: Each shift register advances once on each clock edge where `en` is 1 and `seed_load` is 0. The new state is {state[62:0], state[63]^state[62]^state[60]^state[59]}. On all other edges without a load, the state does not change.
- R3: A clock edge with `seed_load` at 1 writes `seed_a` and `seed_b` into the two registers. A zero seed is replaced by 64'h9E3779B97F4A7C15 for register A and by 64'hD1B54A32D192ED03 for register B.
- R4: The radius value is taken from address k = bits 63:56 of register A. Its value is round(32·sqrt(-2·ln(k/256))), and address 0 uses u = 0.5/256 so that the value stays finite (113).
- R5: The cosine value is taken from address k = bits 63:56 of register B. Its value is the signed integer round(64·cos(2πk/256)).
- R6: The output equals (radius·cosine·sigma + 2^14) >>> 15. The arithmetic shift rounds halves upward. Sigma is sampled on the edge that registers the output.
- R7: The result saturates to the range -32..31, and `sample` is two's complement.
- R8: `sample_valid` on a given edge equals `en` from three edges earlier, and each enabled cycle yields exactly one sample.
- R9: A sample registered while `sigma` is 0 is 0.
- R10: `sample` changes only on edges where `sample_valid` becomes or stays 1. Otherwise it holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Start one sample this cycle |
| seed_load | input | 1 | Load both seeds into the shift registers |
| seed_a | input | 64 | Seed for the radius register |
| seed_b | input | 64 | Seed for the angle register |
| sigma | input | 8 | Standard deviation, unsigned, 4 fraction bits |
| sample | output | 6 | Signed noise sample |
| sample_valid | output | 1 | Sample is new this cycle |

## Verification
The assertions assume that `en` is held low during reset. The latency check relies on this, because it looks back over the first edges after release. The stimulus holds `en` at 0 during reset and keeps it at 0 on every load cycle. The random phase draws `en`, `sigma` and the seeds from a fixed-seed generator. Directed loads force table address 0 and a cosine of ±1 at full sigma, so that both saturation limits are reached.

// File: rtl/gauss_noise_gen.sv
module gauss_noise_gen #(
  parameter int LFSR_W   = 64,
  parameter int ADDR_W   = 8,
  parameter int RAD_W    = 8,
  parameter int RAD_FRAC = 5,
  parameter int COS_W    = 8,
  parameter int COS_FRAC = 6,
  parameter int SIG_W    = 8,
  parameter int SIG_FRAC = 4,
  parameter int OUT_W    = 6,
  parameter logic [LFSR_W-1:0] ZERO_SUB_A = 64'h9E3779B97F4A7C15,
  parameter logic [LFSR_W-1:0] ZERO_SUB_B = 64'hD1B54A32D192ED03
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    seed_load,
  input  logic [LFSR_W-1:0]       seed_a,
  input  logic [LFSR_W-1:0]       seed_b,
  input  logic [SIG_W-1:0]        sigma,
  output logic signed [OUT_W-1:0] sample,
  output logic                    sample_valid
);
  localparam int  DEPTH  = 1 << ADDR_W;
  localparam int  PROD_W = RAD_W + COS_W + 1;
  localparam int  SCL_W  = PROD_W + SIG_W + 1;
  localparam int  SHIFT  = RAD_FRAC + COS_FRAC + SIG_FRAC;
  localparam real PI     = 3.14159265358979323846;
  localparam logic signed [SCL_W-1:0] HALF    = SCL_W'(1) <<< (SHIFT - 1);
  localparam logic signed [SCL_W-1:0] OUT_MAX = SCL_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [SCL_W-1:0] OUT_MIN = -(SCL_W'(1 << (OUT_W - 1)));

  logic [LFSR_W-1:0] lfsr_a, lfsr_b;
  logic [RAD_W-1:0]  rad_rom [DEPTH];
  logic signed [COS_W-1:0] cos_rom [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_rom
    localparam real UK = (k == 0) ? 0.5 / DEPTH : real'(k) / DEPTH;
    localparam int  RV = int'($sqrt(-2.0 * $ln(UK)) * (2.0 ** RAD_FRAC));
    localparam int  CV = int'($cos(2.0 * PI * k / DEPTH) * (2.0 ** COS_FRAC));
    assign rad_rom[k] = RAD_W'(RV);
    assign cos_rom[k] = COS_W'(CV);
  end

  function automatic logic [LFSR_W-1:0] step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[LFSR_W-2] ^ s[LFSR_W-4] ^ s[LFSR_W-5]};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr_a <= ZERO_SUB_A;
      lfsr_b <= ZERO_SUB_B;
    end else if (seed_load) begin
      lfsr_a <= (seed_a == '0) ? ZERO_SUB_A : seed_a;
      lfsr_b <= (seed_b == '0) ? ZERO_SUB_B : seed_b;
    end else if (en) begin
      lfsr_a <= step(lfsr_a);
      lfsr_b <= step(lfsr_b);
    end
  end

  logic [RAD_W-1:0]        rad_q;
  logic signed [COS_W-1:0] cos_q;
  logic signed [PROD_W-1:0] prod_q;
  logic v1, v2;

  wire signed [SCL_W-1:0] scaled  = prod_q * $signed({1'b0, sigma});
  wire signed [SCL_W-1:0] rounded = (scaled + HALF) >>> SHIFT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rad_q        <= '0;
      cos_q        <= '0;
      prod_q       <= '0;
      sample       <= '0;
      v1           <= 1'b0;
      v2           <= 1'b0;
      sample_valid <= 1'b0;
    end else begin
      v1           <= en;
      v2           <= v1;
      sample_valid <= v2;
      if (en) begin
        rad_q <= rad_rom[lfsr_a[LFSR_W-1 -: ADDR_W]];
        cos_q <= cos_rom[lfsr_b[LFSR_W-1 -: ADDR_W]];
      end
      if (v1) prod_q <= $signed({1'b0, rad_q}) * cos_q;
      if (v2) begin
        if (rounded > OUT_MAX)      sample <= OUT_MAX[OUT_W-1:0];
        else if (rounded < OUT_MIN) sample <= OUT_MIN[OUT_W-1:0];
        else                        sample <= rounded[OUT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/gauss_noise_gen_chk.sv
module gauss_noise_gen_chk #(
  parameter int LFSR_W = 64,
  parameter int SIG_W  = 8,
  parameter int OUT_W  = 6,
  parameter logic [LFSR_W-1:0] ZERO_SUB_A = 64'h9E3779B97F4A7C15
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    en,
  input logic                    seed_load,
  input logic [LFSR_W-1:0]       seed_a,
  input logic [SIG_W-1:0]        sigma,
  input logic signed [OUT_W-1:0] sample,
  input logic                    sample_valid,
  input logic [LFSR_W-1:0]       lfsr_a
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assert_valid_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    age == 2'd3 |-> sample_valid == $past(en, 3));

  assert_zero_sigma_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid && $past(sigma) == '0 |-> sample == '0);

  assert_hold_sample_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sample) |-> sample_valid);

  assert_zero_seed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load && seed_a == '0 |=> lfsr_a == ZERO_SUB_A);

  assert_lfsr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !seed_load |=> $stable(lfsr_a));
endmodule

bind gauss_noise_gen gauss_noise_gen_chk #(
  .LFSR_W(LFSR_W), .SIG_W(SIG_W), .OUT_W(OUT_W), .ZERO_SUB_A(ZERO_SUB_A)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .seed_load(seed_load), .seed_a(seed_a),
  .sigma(sigma), .sample(sample), .sample_valid(sample_valid), .lfsr_a(lfsr_a)
);

// File: tb/tb_gauss_noise_gen.sv
module tb_gauss_noise_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, seed_load = 1'b0;
  logic [63:0] seed_a = '0, seed_b = '0;
  logic [7:0] sigma = '0;
  logic signed [5:0] sample;
  logic sample_valid;

  int checks = 0, fails = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  gauss_noise_gen dut (
    .clk(clk), .rst_n(rst_n), .en(en), .seed_load(seed_load),
    .seed_a(seed_a), .seed_b(seed_b), .sigma(sigma),
    .sample(sample), .sample_valid(sample_valid));

  localparam logic [63:0] SUB_A = 64'h9E3779B97F4A7C15;
  localparam logic [63:0] SUB_B = 64'hD1B54A32D192ED03;
  localparam real PI = 3.14159265358979323846;

  logic [63:0] ma, mb;
  int m_rad, m_cs, m_p, m_out;
  bit m_v1, m_v2, m_v3;

  function automatic int rad_tab(input int k);
    real u = (k == 0) ? 0.5 / 256.0 : real'(k) / 256.0;
    return int'($sqrt(-2.0 * $ln(u)) * 32.0);
  endfunction

  function automatic int cos_tab(input int k);
    return int'($cos(2.0 * PI * k / 256.0) * 64.0);
  endfunction

  function automatic logic [63:0] nxt(input logic [63:0] s);
    return {s[62:0], s[63] ^ s[62] ^ s[60] ^ s[59]};
  endfunction

  function automatic int expect_out(input int p, input int sg);
    int r = (p * sg + 16384) >>> 15;
    if (r > 31) r = 31;
    if (r < -32) r = -32;
    return r;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input bit e, input bit ld, input logic [63:0] sa,
                      input logic [63:0] sb, input logic [7:0] sg);
    en = e; seed_load = ld; seed_a = sa; seed_b = sb; sigma = sg;
    @(posedge clk);
    if (m_v2) m_out = expect_out(m_p, int'(sg));
    m_v3 = m_v2;
    if (m_v1) m_p = m_rad * m_cs;
    m_v2 = m_v1;
    if (e) begin
      m_rad = rad_tab(int'(ma[63:56]));
      m_cs  = cos_tab(int'(mb[63:56]));
    end
    m_v1 = e;
    if (ld) begin
      ma = (sa == '0) ? SUB_A : sa;
      mb = (sb == '0) ? SUB_B : sb;
    end else if (e) begin
      ma = nxt(ma);
      mb = nxt(mb);
    end
    @(negedge clk);
    check("R8", int'(sample_valid), int'(m_v3));
    check({tag, " R10"}, int'(sample), m_out);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    ma = SUB_A; mb = SUB_B;
    m_rad = 0; m_cs = 0; m_p = 0; m_out = 0;
    m_v1 = 0; m_v2 = 0; m_v3 = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1", int'(sample_valid), 0);
    check("R1", int'(sample), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", int'(sample_valid), 0);
    check("R1 after release", int'(sample), 0);

    // R2 R4 R5 R6: random enable pattern and sigma
    tag = "R2 R4 R5 R6";
    tick(0, 1, {$urandom, $urandom}, {$urandom, $urandom}, 8'd16);
    for (int i = 0; i < 400; i++)
      tick(($urandom % 4) != 0, 0, '0, '0, 8'($urandom));
    repeat (3) tick(0, 0, '0, '0, 8'd16);

    // R3: zero seeds replaced
    tag = "R3";
    tick(0, 1, '0, '0, 8'd16);
    for (int i = 0; i < 40; i++) tick(1, 0, '0, '0, 8'd24);
    repeat (3) tick(0, 0, '0, '0, 8'd24);

    // R4 R7: address 0 radius with cos +1 and -1 at full sigma
    tag = "R4 R7";
    tick(0, 1, 64'h00A5A5A5A5A5A5A5, 64'h003C3C3C3C3C3C3C, 8'd255);
    tick(1, 0, '0, '0, 8'd255);
    repeat (2) tick(0, 0, '0, '0, 8'd255);
    check("R7 positive limit", int'(sample), 31);
    tick(0, 1, 64'h00A5A5A5A5A5A5A5, 64'h803C3C3C3C3C3C3C, 8'd255);
    tick(1, 0, '0, '0, 8'd255);
    repeat (2) tick(0, 0, '0, '0, 8'd255);
    check("R7 negative limit", int'(sample), -32);

    // R9: sigma zero gives zero
    tag = "R9";
    tick(1, 0, '0, '0, 8'd0);
    repeat (2) tick(0, 0, '0, '0, 8'd0);
    check("R9", int'(sample), 0);

    // R6 R7: random seeds with big sigma
    tag = "R6 R7";
    for (int j = 0; j < 8; j++) begin
      tick(0, 1, {$urandom, $urandom}, {$urandom, $urandom}, 8'd200);
      for (int i = 0; i < 30; i++) tick($urandom % 2, 0, '0, '0, 8'(128 + $urandom % 128));
    end
    repeat (3) tick(0, 0, '0, '0, 8'd16);

    // R2 R10: long idle gap then resume
    tag = "R2 R10";
    repeat (20) tick(0, 0, '0, '0, 8'd50);
    for (int i = 0; i < 20; i++) tick(1, 0, '0, '0, 8'd50);
    repeat (3) tick(0, 0, '0, '0, 8'd50);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule